// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel. Each transfer moves a single data item between a peripheral port and a memory port. The transfer is a read from the source on a simple valid/ready bus-master port, followed by a write of the converted item to the destination. Software loads a programmed item count while the channel is off. The peripheral and memory base addresses and the mode inputs are static configuration. Hidden working registers carry the live count and the two current pointers. The programmed values are never changed by traffic.

In peripheral-paced mode each item is triggered by a four-phase request/acknowledge exchange with one peripheral. In memory-to-memory mode the channel triggers itself as soon as it is enabled. Circular mode restarts the pass when the last item is done. A bus error on either access turns the channel off in hardware. The block gives out one-cycle half-pass, pass-complete and error event pulses for an external flag register.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is disabled, `perAck` and `busValid` are low and `remaining` is 0.
- R2: Every transfer is one read (`busWrite`=0) from the source, then one write (`busWrite`=1) to the destination. With `cfgDir`=0 the peripheral port is the source; with `cfgDir`=1 the memory port is the source.
- R3: Peripheral handshake. The channel starts an item only while `perReq` is high and `perAck` is low. `perAck` rises in the cycle after the write is accepted. It stays high while `perReq` is high and falls on the first edge that samples `perReq` low.
- R4: `remaining` loads the programmed count on the rising edge of the enable and drops by one per completed transfer. While it is 0, no bus access and no acknowledge occur.
- R5: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. With a port's increment input set, its pointer advances by its size after each transfer; otherwise the pointer stays fixed. The address driven on the bus has its low bits cleared to the size's alignment.
- R6: The written item is the read item cut to the source size, then zero-extended or truncated to the destination size (`busWdata` lanes above the destination size are 0).
- R7: With `cfgCirc`=1 and `cfgM2m`=0, completing the last item reloads the count and both pointers in the same edge, and service continues.
- R8: Without reload the channel stops at count 0. A count write (`cntWr`) while the channel is enabled is ignored.
- R9: With `cfgM2m`=1 transfers start without any request, `perAck` stays low, and the run stops at count 0 even if `cfgCirc`=1.
- R10: A bus error on either access pulses `evtErr`, clears the enable on the next edge, and leaves `remaining` unchanged for the failed item, with no `evtDone`.
- R11: `evtHalf` pulses once per pass, when the items moved in that pass reach the programmed count shifted right by one (never for a count below 2). `evtDone` pulses when the last item of a pass completes.
- R12: While `busValid` is high and `busReady` is low, `busValid`, `busAddr` and `busWrite` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enSet | input | 1 | Pulse: turn the channel on |
| enClr | input | 1 | Pulse: turn the channel off |
| cntWr | input | 1 | Pulse: write the programmed count (only while disabled) |
| cntWrData | input | CNT_W | Count value to write |
| cfgDir | input | 1 | 0: peripheral is source, 1: memory is source |
| cfgCirc | input | 1 | Circular reload enable |
| cfgPinc | input | 1 | Peripheral pointer increment |
| cfgMinc | input | 1 | Memory pointer increment |
| cfgPsize | input | 2 | Peripheral item size code |
| cfgMsize | input | 2 | Memory item size code |
| cfgM2m | input | 1 | Memory-to-memory self-trigger |
| perBase | input | ADDR_W | Peripheral base address |
| memBase | input | ADDR_W | Memory base address |
| perReq | input | 1 | Peripheral request |
| perAck | output | 1 | Acknowledge to peripheral |
| chEnable | output | 1 | Channel enable state |
| remaining | output | CNT_W | Items left in the current pass |
| busValid | output | 1 | Bus access valid |
| busWrite | output | 1 | Bus access is a write |
| busAddr | output | ADDR_W | Aligned bus address |
| busSize | output | 2 | Size code of the access |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Access accepted this cycle |
| busRdata | input | 32 | Read data, valid with busReady |
| busErr | input | 1 | Access failed, valid with busReady |
| evtHalf | output | 1 | Half-pass event pulse |
| evtDone | output | 1 | Pass-complete event pulse |
| evtErr | output | 1 | Transfer error event pulse |

## Verification
Completing the last item of a circular pass happens in the same edge as the count reload, the pointer reload and the normal pointer step, and the reload must win over the step. The bench runs a three-item circular pass and then a fourth transfer. That fourth transfer must read and write the base addresses again, `evtHalf` must fire a second time, and `remaining` must show the reloaded count minus one. A bus error on the final write of a pass also meets the completion logic in the same cycle. A one-item run that fails on its write must raise the error alone and leave the count at 1.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;   // copy base addresses into current pointers
    logic stepPtr;   // post-increment pointers after a transfer
    logic capture;   // latch read data
    logic wrPhase;   // bus is in write access
  } dpCtl_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] laneMask(input logic [1:0] sz);
    case (sz)
      2'd0:    laneMask = 32'h0000_00FF;
      2'd1:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              cfgDir,
  input  logic              cfgPinc,
  input  logic              cfgMinc,
  input  logic [1:0]        cfgPsize,
  input  logic [1:0]        cfgMsize,
  input  logic [ADDR_W-1:0] perBase,
  input  logic [ADDR_W-1:0] memBase,
  input  logic [WORD_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [WORD_W-1:0] busWdata
);

  logic [ADDR_W-1:0] perPtr, memPtr;
  logic [WORD_W-1:0] dataReg;
  logic [1:0]        srcSize, dstSize;
  logic [ADDR_W-1:0] srcPtr, dstPtr;

  function automatic logic [ADDR_W-1:0] alignTo(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] sz);
    alignTo = a & ~ADDR_W'(sizeBytes(sz) - 3'd1);
  endfunction

  assign srcSize = cfgDir ? cfgMsize : cfgPsize;
  assign dstSize = cfgDir ? cfgPsize : cfgMsize;
  assign srcPtr  = cfgDir ? memPtr : perPtr;
  assign dstPtr  = cfgDir ? perPtr : memPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perPtr <= '0;
      memPtr <= '0;
    end else if (ctl.loadPtr) begin
      perPtr <= perBase;
      memPtr <= memBase;
    end else if (ctl.stepPtr) begin
      if (cfgPinc) perPtr <= perPtr + ADDR_W'(sizeBytes(cfgPsize));
      if (cfgMinc) memPtr <= memPtr + ADDR_W'(sizeBytes(cfgMsize));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (ctl.capture) dataReg <= busRdata & laneMask(srcSize);
  end

  assign busAddr  = ctl.wrPhase ? alignTo(dstPtr, dstSize) : alignTo(srcPtr, srcSize);
  assign busSize  = ctl.wrPhase ? dstSize : srcSize;
  assign busWdata = dataReg & laneMask(dstSize);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cfgCirc,
  input  logic             cfgM2m,
  input  logic             perReq,
  input  logic             busReady,
  input  logic             busErr,
  output logic             perAck,
  output logic             chEnable,
  output logic [CNT_W-1:0] remaining,
  output logic             busValid,
  output logic             busWrite,
  output dpCtl_t           ctl,
  output logic             evtHalf,
  output logic             evtDone,
  output logic             evtErr
);

  seqState_e        state, stateNext;
  logic             en, ack, enNext, enRise;
  logic [CNT_W-1:0] progCount, count, nextCount, halfMark;
  logic             finish, errHit, xferDone, lastItem, reload, startOk;

  assign busValid  = (state != ST_IDLE);
  assign busWrite  = (state == ST_WRITE);
  assign finish    = busValid & busReady;
  assign errHit    = finish & busErr;
  assign xferDone  = busWrite & finish & ~busErr;
  assign lastItem  = (count == CNT_W'(1));
  assign reload    = cfgCirc & ~cfgM2m;
  assign nextCount = count - CNT_W'(1);
  assign halfMark  = progCount >> 1;
  assign startOk   = en & (count != '0) & (cfgM2m | (perReq & ~ack));

  always_comb begin
    if (errHit)     enNext = 1'b0;
    else if (enClr) enNext = 1'b0;
    else if (enSet) enNext = 1'b1;
    else            enNext = en;
  end
  assign enRise = enNext & ~en;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startOk) stateNext = ST_READ;
      ST_READ:  if (finish)  stateNext = busErr ? ST_IDLE : ST_WRITE;
      ST_WRITE: if (finish)  stateNext = ST_IDLE;
      default:               stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      en        <= 1'b0;
      ack       <= 1'b0;
      progCount <= '0;
      count     <= '0;
    end else begin
      state <= stateNext;
      en    <= enNext;
      if (cntWr && !en) progCount <= cntWrData;
      if (xferDone && !cfgM2m)  ack <= 1'b1;
      else if (ack && !perReq)  ack <= 1'b0;
      if (enRise)                         count <= progCount;
      else if (xferDone && lastItem && reload) count <= progCount;
      else if (xferDone)                  count <= nextCount;
    end
  end

  assign ctl.loadPtr = enRise | (xferDone & lastItem & reload);
  assign ctl.stepPtr = xferDone;
  assign ctl.capture = (state == ST_READ) & finish & ~busErr;
  assign ctl.wrPhase = busWrite;

  assign evtDone = xferDone & lastItem;
  assign evtHalf = xferDone & (halfMark != '0) & (nextCount == progCount - halfMark);
  assign evtErr  = errHit;

  assign perAck    = ack;
  assign chEnable  = en;
  assign remaining = count;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enSet,
  input  logic              enClr,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              cfgDir,
  input  logic              cfgCirc,
  input  logic              cfgPinc,
  input  logic              cfgMinc,
  input  logic [1:0]        cfgPsize,
  input  logic [1:0]        cfgMsize,
  input  logic              cfgM2m,
  input  logic [ADDR_W-1:0] perBase,
  input  logic [ADDR_W-1:0] memBase,
  input  logic              perReq,
  output logic              perAck,
  output logic              chEnable,
  output logic [CNT_W-1:0]  remaining,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [31:0]       busWdata,
  input  logic              busReady,
  input  logic [31:0]       busRdata,
  input  logic              busErr,
  output logic              evtHalf,
  output logic              evtDone,
  output logic              evtErr
);

  dpCtl_t ctl;

  dma_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enSet     (enSet),
    .enClr     (enClr),
    .cntWr     (cntWr),
    .cntWrData (cntWrData),
    .cfgCirc   (cfgCirc),
    .cfgM2m    (cfgM2m),
    .perReq    (perReq),
    .busReady  (busReady),
    .busErr    (busErr),
    .perAck    (perAck),
    .chEnable  (chEnable),
    .remaining (remaining),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .ctl       (ctl),
    .evtHalf   (evtHalf),
    .evtDone   (evtDone),
    .evtErr    (evtErr)
  );

  dma_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cfgDir   (cfgDir),
    .cfgPinc  (cfgPinc),
    .cfgMinc  (cfgMinc),
    .cfgPsize (cfgPsize),
    .cfgMsize (cfgMsize),
    .perBase  (perBase),
    .memBase  (memBase),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata)
  );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              perReq,
  input logic              perAck,
  input logic              chEnable,
  input logic [CNT_W-1:0]  remaining,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReady,
  input logic              busErr,
  input logic              evtErr
);

  // R3: acknowledge drops only after the request was seen low
  assert_ack_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(perAck) |-> !$past(perReq));

  // R3: acknowledge rises only after an accepted, error-free write
  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perAck) |-> $past(busValid && busWrite && busReady && !busErr));

  // R4: a new access never starts while the count is zero
  assert_no_start_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> ($past(remaining) != '0));

  // R10: a bus error leaves the channel disabled on the next cycle
  assert_err_disables_R10: assert property (@(posedge clk) disable iff (!rstN)
    evtErr |=> !chEnable);

  // R12: a stalled access holds its request
  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWrite)));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .perReq    (perReq),
  .perAck    (perAck),
  .chEnable  (chEnable),
  .remaining (remaining),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busReady  (busReady),
  .busErr    (busErr),
  .evtErr    (evtErr)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enSet = 0, enClr = 0, cntWr = 0;
  logic [15:0] cntWrData = '0;
  logic        cfgDir = 0, cfgCirc = 0, cfgPinc = 0, cfgMinc = 0, cfgM2m = 0;
  logic [1:0]  cfgPsize = '0, cfgMsize = '0;
  logic [31:0] perBase = '0, memBase = '0;
  logic        perReq = 0;
  logic        perAck, chEnable, busValid, busWrite, busReady, busErr;
  logic        evtHalf, evtDone, evtErr;
  logic [15:0] remaining;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [1:0]  busSize;

  logic        readyEn = 1'b1;
  logic        errOn = 1'b0;
  logic [31:0] errAddr = '0;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] memVal(input logic [31:0] a);
    memVal = {a[7:0] ^ 8'hC3, a[7:0] ^ 8'h96, a[7:0] ^ 8'h69, a[7:0] ^ 8'h3C};
  endfunction

  assign busReady = busValid & readyEn;
  assign busErr   = busValid & errOn & (busAddr == errAddr);
  assign busRdata = memVal(busAddr);

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr), .cntWr(cntWr),
    .cntWrData(cntWrData), .cfgDir(cfgDir), .cfgCirc(cfgCirc), .cfgPinc(cfgPinc),
    .cfgMinc(cfgMinc), .cfgPsize(cfgPsize), .cfgMsize(cfgMsize), .cfgM2m(cfgM2m),
    .perBase(perBase), .memBase(memBase), .perReq(perReq), .perAck(perAck),
    .chEnable(chEnable), .remaining(remaining), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .busErr(busErr), .evtHalf(evtHalf),
    .evtDone(evtDone), .evtErr(evtErr)
  );

  // monotonic logs of accepted accesses and events
  logic [31:0] wrAddr [64];
  logic [31:0] wrData [64];
  logic [31:0] rdAddr [64];
  int wrCnt = 0, rdCnt = 0, halfCnt = 0, doneCnt = 0, errCnt = 0, ackCycles = 0;

  always @(posedge clk) begin
    if (busValid && busReady && !busErr) begin
      if (busWrite && wrCnt < 64) begin
        wrAddr[wrCnt] <= busAddr;
        wrData[wrCnt] <= busWdata;
        wrCnt <= wrCnt + 1;
      end else if (!busWrite && rdCnt < 64) begin
        rdAddr[rdCnt] <= busAddr;
        rdCnt <= rdCnt + 1;
      end
    end
    if (evtHalf) halfCnt <= halfCnt + 1;
    if (evtDone) doneCnt <= doneCnt + 1;
    if (evtErr)  errCnt  <= errCnt + 1;
    if (perAck)  ackCycles <= ackCycles + 1;
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic dir, circ, pinc, minc, input logic [1:0] ps, ms,
                       input logic m2m, input logic [31:0] pb, mb, input logic [15:0] cnt);
    @(negedge clk);
    cfgDir = dir; cfgCirc = circ; cfgPinc = pinc; cfgMinc = minc;
    cfgPsize = ps; cfgMsize = ms; cfgM2m = m2m; perBase = pb; memBase = mb;
    cntWr = 1'b1; cntWrData = cnt;
    @(negedge clk);
    cntWr = 1'b0;
    enSet = 1'b1;
    @(negedge clk);
    enSet = 1'b0;
  endtask

  task automatic disableCh();
    @(negedge clk);
    enClr = 1'b1;
    @(negedge clk);
    enClr = 1'b0;
  endtask

  // one four-phase peripheral exchange with ordering checks (R3)
  task automatic periphXfer();
    int waitN = 0;
    @(negedge clk);
    perReq = 1'b1;
    while (!perAck && waitN < 20) begin
      @(negedge clk);
      waitN++;
    end
    checkEq("R3 ack seen", perAck, 1'b1);
    @(negedge clk);
    checkEq("R3 ack held while request high", perAck, 1'b1);
    perReq = 1'b0;
    @(negedge clk);
    checkEq("R3 ack dropped after request low", perAck, 1'b0);
  endtask

  task automatic testReset();
    checkEq("R1 enable", chEnable, 1'b0);
    checkEq("R1 ack", perAck, 1'b0);
    checkEq("R1 valid", busValid, 1'b0);
    checkEq("R1 remaining", remaining, 32'd0);
  endtask

  task automatic testPeriphToMem();
    int w0 = wrCnt, r0 = rdCnt, h0 = halfCnt, d0 = doneCnt;
    setup(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 32'h4000_0003, 32'h2000_0001, 16'd4);
    checkEq("R4 count loaded on enable", remaining, 32'd4);
    checkEq("R9 no self trigger without m2m", busValid, 1'b0);
    for (int i = 0; i < 4; i++) periphXfer();
    checkEq("R4 write count", wrCnt - w0, 32'd4);
    for (int i = 0; i < 4; i++) begin
      checkEq("R2 read from fixed peripheral", rdAddr[r0+i], 32'h4000_0003);
      checkEq("R5 memory word step, aligned", wrAddr[w0+i], 32'h2000_0000 + 32'(4*i));
      checkEq("R6 byte zero-extended to word", wrData[w0+i], memVal(32'h4000_0003) & 32'hFF);
    end
    checkEq("R11 half once", halfCnt - h0, 32'd1);
    checkEq("R11 done once", doneCnt - d0, 32'd1);
    checkEq("R8 stopped at zero", remaining, 32'd0);
    @(negedge clk);
    perReq = 1'b1;
    repeat (10) @(negedge clk);
    checkEq("R4 no ack at zero count", perAck, 1'b0);
    checkEq("R8 no access after last item", wrCnt - w0, 32'd4);
    perReq = 1'b0;
    disableCh();
  endtask

  task automatic testCircular();
    int w0 = wrCnt, r0 = rdCnt, h0 = halfCnt, d0 = doneCnt;
    logic [31:0] srcA;
    setup(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 32'h0000_0200, 32'h0000_0101, 16'd3);
    for (int i = 0; i < 4; i++) periphXfer();
    for (int i = 0; i < 4; i++) begin
      srcA = 32'h100 + 32'(2 * (i % 3));
      checkEq("R2 R7 memory source address", rdAddr[r0+i], srcA);
      checkEq("R7 peripheral dest address", wrAddr[w0+i], 32'h200 + 32'(i % 3));
      checkEq("R6 halfword cut to byte", wrData[w0+i], memVal(srcA) & 32'hFF);
    end
    checkEq("R7 done after pass", doneCnt - d0, 32'd1);
    checkEq("R11 half again after reload", halfCnt - h0, 32'd2);
    checkEq("R7 count reloaded then decremented", remaining, 32'd2);
    checkEq("R7 still enabled", chEnable, 1'b1);
    disableCh();
  endtask

  task automatic testMemToMem();
    int w0 = wrCnt, h0 = halfCnt, d0 = doneCnt, a0 = ackCycles;
    readyEn = 1'b0;
    setup(1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2, 1'b1, 32'h0000_0402, 32'h0000_0300, 16'd5);
    repeat (4) @(negedge clk);
    checkEq("R12 stalled read valid", busValid, 1'b1);
    checkEq("R12 stalled read address", busAddr, 32'h300);
    checkEq("R12 stalled access is read", busWrite, 1'b0);
    readyEn = 1'b1;
    repeat (30) @(negedge clk);
    checkEq("R9 writes", wrCnt - w0, 32'd5);
    for (int i = 0; i < 5; i++) begin
      checkEq("R5 halfword peripheral step", wrAddr[w0+i], 32'h402 + 32'(2*i));
      checkEq("R6 word cut to halfword", wrData[w0+i], memVal(32'h300 + 32'(4*i)) & 32'hFFFF);
    end
    checkEq("R9 no reload in m2m", remaining, 32'd0);
    checkEq("R9 no acknowledge", ackCycles - a0, 32'd0);
    checkEq("R11 half at two of five", halfCnt - h0, 32'd1);
    checkEq("R11 done", doneCnt - d0, 32'd1);
    disableCh();
  endtask

  task automatic testErrors();
    int w0 = wrCnt, e0 = errCnt, d0 = doneCnt, h0 = halfCnt;
    errAddr = 32'h2004; errOn = 1'b1;
    setup(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 1'b1, 32'h1000, 32'h2000, 16'd4);
    repeat (30) @(negedge clk);
    checkEq("R10 one write before error", wrCnt - w0, 32'd1);
    checkEq("R10 error event", errCnt - e0, 32'd1);
    checkEq("R10 enable cleared", chEnable, 1'b0);
    checkEq("R10 failed item not counted", remaining, 32'd3);
    checkEq("R10 no done", doneCnt - d0, 32'd0);
    // error on the final write of a one-item run
    errAddr = 32'h2000;
    w0 = wrCnt; e0 = errCnt; d0 = doneCnt;
    setup(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 1'b1, 32'h1000, 32'h2000, 16'd1);
    repeat (20) @(negedge clk);
    checkEq("R10 last-item error event", errCnt - e0, 32'd1);
    checkEq("R10 last-item count kept", remaining, 32'd1);
    checkEq("R10 last-item no done", doneCnt - d0, 32'd0);
    checkEq("R11 no half for small count", halfCnt - h0, 32'd0);
    checkEq("R10 last-item no write", wrCnt - w0, 32'd0);
    errOn = 1'b0;
  endtask

  task automatic testCountLock();
    setup(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h10, 32'h20, 16'd7);
    @(negedge clk);
    cntWr = 1'b1; cntWrData = 16'd9;
    @(negedge clk);
    cntWr = 1'b0;
    disableCh();
    @(negedge clk);
    enSet = 1'b1;
    @(negedge clk);
    enSet = 1'b0;
    checkEq("R8 count write while enabled ignored", remaining, 32'd7);
    disableCh();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriphToMem();
    testCircular();
    testMemToMem();
    testErrors();
    testCountLock();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule